// File: doc/BRIEF.md
# Clause-22 Station Management Master

This block is a station-management master. It runs clause-22 read and write frames to PHY devices over a management clock and data line pair. Software drives it through a small register window. It selects the target device and register in an address register. It starts a read by setting a command bit and starts a write by writing the data register. It then polls a busy indicator and collects read data from a status register.

The management clock comes from the system clock through a parameterised divider, and it runs only while a frame is on the wire. A frame engine walks through five named states. IDLE goes to PREAMBLE on a launch pulse. PREAMBLE goes to HEADER after 32 ones. HEADER goes to TURN after the start, opcode and two 5-bit address fields. TURN goes to DATA after two turnaround bits. DATA goes back to IDLE after 16 data bits. Every transition except the launch happens on a falling tick of the management clock.

Top module: `sta_mgmt_master`

## Requirements
- R1: Register select 1 (address) holds the device address in bits 12:8 and the register address in bits 4:0 of the written word. Reading it back returns only those two fields, and all other bits read zero.
- R2: Register select 0 (command) holds a read bit in bit 0. A read frame is launched only when a write changes that bit from 0 to 1. Writing 1 while it is already 1 launches nothing.
- R3: A write to register select 2 (write data) stores bits 15:0 and launches a write frame to the device and register held in the address register. The addressed PHY register then holds that value.
- R4: Register select 4 (indicator) reads busy in bit 0 and zero elsewhere. Busy rises the cycle after the launching write is taken and stays 1 for exactly 64 × CLK_DIV cycles.
- R5: Register select 3 (status) returns the last read data in bits 15:0, with bits 31:16 zero. It changes only in the cycle a read frame completes. A device that does not answer yields 0xFFFF from the pull-up.
- R6: A frame is 32 ones, then start 0,1, then opcode 1,0 (read) or 0,1 (write), then device address and register address MSB first. A write frame then sends turnaround 1,0 and 16 data bits MSB first.
- R7: In a read frame, mdio_oe is low for the two turnaround bits and the 16 data bits.
- R8: Each bit lasts CLK_DIV cycles: mdc is low for the first CLK_DIV/2 cycles and high for the rest. mdio_o and mdio_oe change only while mdc is low. Read data is sampled as mdc rises.
- R9: Writes to select 0, 1 or 2 are ignored while a frame is pending or busy.
- R10: Outside a frame, mdc, mdio_oe and mdio_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_sel | input | 3 | Register select: 0 command, 1 address, 2 write data, 3 status, 4 indicator |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data line as seen at the pin |

## Verification
The bench reads from the PHY device and from an absent device, which separates real captured data from the 0xFFFF pull-up result. Write frames use the all-ones, all-zeros and edge-bit values 0x8001 and 0x1234 to lowest, highest and middle register numbers. A wrongly ordered or shifted data field therefore lands in the wrong PHY entry or value. A repeated set of the read bit without a clear tells edge-triggered launch from level-triggered launch. Register writes issued mid-frame show whether the lock holds.

// File: rtl/sta_mgmt_pkg.sv
package sta_mgmt_pkg;

    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 14;
    localparam int TA_BITS    = 2;
    localparam int DATA_BITS  = 16;
    localparam int FRAME_BITS = PRE_BITS + HDR_BITS + TA_BITS + DATA_BITS;
    localparam int SHIFT_BITS = HDR_BITS + TA_BITS + DATA_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam logic [2:0] SEL_CMD    = 3'd0;
    localparam logic [2:0] SEL_ADDR   = 3'd1;
    localparam logic [2:0] SEL_WDATA  = 3'd2;
    localparam logic [2:0] SEL_STATUS = 3'd3;
    localparam logic [2:0] SEL_IND    = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } frame_state_e;

    typedef struct packed {
        logic [4:0] dev;
        logic [4:0] regad;
    } mgmt_target_t;

endpackage

// File: rtl/sta_mgmt_clkdiv.sv
module sta_mgmt_clkdiv #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = $clog2(CLK_DIV);
    localparam logic [CW-1:0] HALF_LAST = CW'(CLK_DIV / 2 - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            mdc     <= 1'b0;
        end else if (!run) begin
            phase_q <= '0;
            mdc     <= 1'b0;
        end else if (phase_q == FULL_LAST) begin
            phase_q <= '0;
            mdc     <= 1'b0;
        end else begin
            phase_q <= phase_q + 1'b1;
            if (phase_q == HALF_LAST) begin
                mdc <= 1'b1;
            end
        end
    end

    assign rise_tick = run && (phase_q == HALF_LAST);
    assign fall_tick = run && (phase_q == FULL_LAST);

    // R8: the clock rises only out of its low half
    a_r8_rise_from_low: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |-> !mdc);

endmodule

// File: rtl/sta_mgmt_regs.sv
module sta_mgmt_regs
    import sta_mgmt_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic [2:0]   bus_sel,
    input  logic [15:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    input  logic         busy,
    input  logic         rd_done,
    input  logic [DATA_BITS-1:0] rd_data,
    output mgmt_target_t target,
    output logic [DATA_BITS-1:0] wr_data,
    output logic         launch,
    output logic         launch_read
);
    logic                 cmd_q;
    logic [DATA_BITS-1:0] status_q;
    logic                 locked;

    assign locked = busy || launch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q       <= 1'b0;
            target      <= '0;
            wr_data     <= '0;
            launch      <= 1'b0;
            launch_read <= 1'b0;
        end else begin
            launch <= 1'b0;
            if (bus_we && !locked) begin
                case (bus_sel)
                    SEL_CMD: begin
                        cmd_q <= bus_wdata[0];
                        if (bus_wdata[0] && !cmd_q) begin
                            launch      <= 1'b1;
                            launch_read <= 1'b1;
                        end
                    end
                    SEL_ADDR: begin
                        target.dev   <= bus_wdata[12:8];
                        target.regad <= bus_wdata[4:0];
                    end
                    SEL_WDATA: begin
                        wr_data     <= bus_wdata;
                        launch      <= 1'b1;
                        launch_read <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (rd_done) begin
            status_q <= rd_data;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_sel)
            SEL_CMD:    bus_rdata[0]    = cmd_q;
            SEL_ADDR:   bus_rdata       = {19'b0, target.dev, 3'b0, target.regad};
            SEL_WDATA:  bus_rdata[15:0] = wr_data;
            SEL_STATUS: bus_rdata[15:0] = status_q;
            SEL_IND:    bus_rdata[0]    = busy;
            default:    bus_rdata       = '0;
        endcase
    end

    // R9: software-visible registers freeze while a frame is pending or running
    a_r9_regs_locked: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable({cmd_q, target, wr_data}));

    // R5: status moves only on read completion
    a_r5_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |=> $stable(status_q));

endmodule

// File: rtl/sta_mgmt_fsm.sv
module sta_mgmt_fsm
    import sta_mgmt_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         launch,
    input  logic         launch_read,
    input  mgmt_target_t target,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic         rise_tick,
    input  logic         fall_tick,
    input  logic         mdio_i,
    output logic         busy,
    output logic         mdio_o,
    output logic         mdio_oe,
    output logic         rd_done,
    output logic [DATA_BITS-1:0] rd_data
);
    localparam logic [IDX_W-1:0] LAST_PRE  = IDX_W'(PRE_BITS - 1);
    localparam logic [IDX_W-1:0] LAST_HDR  = IDX_W'(PRE_BITS + HDR_BITS - 1);
    localparam logic [IDX_W-1:0] LAST_TA   = IDX_W'(PRE_BITS + HDR_BITS + TA_BITS - 1);
    localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(FRAME_BITS - 1);

    frame_state_e           state, state_nx;
    logic [IDX_W-1:0]       bit_idx;
    logic [SHIFT_BITS-1:0]  shift_q;
    logic                   is_read;
    logic [DATA_BITS-1:0]   cap_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (launch)                           state_nx = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_tick && bit_idx == LAST_PRE)  state_nx = ST_HEADER;
            ST_HEADER:   if (fall_tick && bit_idx == LAST_HDR)  state_nx = ST_TURN;
            ST_TURN:     if (fall_tick && bit_idx == LAST_TA)   state_nx = ST_DATA;
            ST_DATA:     if (fall_tick && bit_idx == LAST_DATA) state_nx = ST_IDLE;
            default:                                           state_nx = ST_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            shift_q <= '0;
            is_read <= 1'b0;
            cap_q   <= '0;
        end else begin
            if (state == ST_IDLE) begin
                if (launch) begin
                    bit_idx <= '0;
                    is_read <= launch_read;
                    shift_q <= {2'b01,
                                launch_read ? 2'b10 : 2'b01,
                                target.dev, target.regad,
                                launch_read ? 2'b00 : 2'b10,
                                launch_read ? {DATA_BITS{1'b0}} : wr_data};
                end
            end else if (fall_tick) begin
                bit_idx <= bit_idx + 1'b1;
                if (state != ST_PREAMBLE) begin
                    shift_q <= {shift_q[SHIFT_BITS-2:0], 1'b0};
                end
            end
            if (rise_tick && state == ST_DATA && is_read) begin
                cap_q <= {cap_q[DATA_BITS-2:0], mdio_i};
            end
        end
    end

    // outputs
    always_comb begin
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                mdio_oe = 1'b0;
                mdio_o  = 1'b0;
            end
            ST_PREAMBLE: begin
                mdio_oe = 1'b1;
                mdio_o  = 1'b1;
            end
            ST_HEADER: begin
                mdio_oe = 1'b1;
                mdio_o  = shift_q[SHIFT_BITS-1];
            end
            ST_TURN, ST_DATA: begin
                mdio_oe = !is_read;
                mdio_o  = !is_read && shift_q[SHIFT_BITS-1];
            end
            default: ;
        endcase
    end

    assign busy    = (state != ST_IDLE);
    assign rd_done = fall_tick && is_read && state == ST_DATA && bit_idx == LAST_DATA;
    assign rd_data = cap_q;

    // R7: the line is released through turnaround and data of a read
    a_r7_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && (state == ST_TURN || state == ST_DATA)) |-> !mdio_oe);

endmodule

// File: rtl/sta_mgmt_master.sv
module sta_mgmt_master
    import sta_mgmt_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [2:0]  bus_sel,
    input  logic [15:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic                 busy, rd_done, launch, launch_read;
    logic                 rise_tick, fall_tick;
    logic [DATA_BITS-1:0] rd_data, wr_data;
    mgmt_target_t         target;

    sta_mgmt_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    sta_mgmt_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_sel     (bus_sel),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .busy        (busy),
        .rd_done     (rd_done),
        .rd_data     (rd_data),
        .target      (target),
        .wr_data     (wr_data),
        .launch      (launch),
        .launch_read (launch_read)
    );

    sta_mgmt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_read (launch_read),
        .target      (target),
        .wr_data     (wr_data),
        .rise_tick   (rise_tick),
        .fall_tick   (fall_tick),
        .mdio_i      (mdio_i),
        .busy        (busy),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .rd_done     (rd_done),
        .rd_data     (rd_data)
    );

    // R8: the data line moves only while the management clock is low
    a_r8_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({mdio_o, mdio_oe}) |-> !mdc);

    // R10: nothing toggles or drives outside a frame
    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe && !mdio_o));

    // R4: a launch pulse is followed by busy
    a_r4_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

endmodule

// File: tb/sta_mgmt_master_test.sv
module sta_mgmt_master_test;
    localparam int DIV    = 8;
    localparam int FRAME  = 64;
    localparam logic [4:0] PHY_ADDR = 5'h02;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_sel = 3'd4;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_oe = 1'b0, phy_o = 1'b0;

    int n_cmp = 0, n_bad = 0;
    logic [2:0] watch_sel = 3'd4;

    always #2.5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    sta_mgmt_master #(.CLK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // ---------------- PHY model ----------------
    logic [15:0] phy_mem [32];
    logic [15:0] exp_mem [32];

    initial begin
        for (int i = 0; i < 32; i++) begin
            phy_mem[i] = 16'hA500 ^ 16'(i * 16'h0111);
            exp_mem[i] = 16'hA500 ^ 16'(i * 16'h0111);
        end
    end

    initial begin
        int ones;
        logic [11:0] hdr;
        logic [15:0] d;
        forever begin
            ones = 0;
            forever begin
                @(posedge mdc);
                if (mdio_i) ones++;
                else if (ones >= 32) break;
                else ones = 0;
            end
            @(posedge mdc);
            for (int i = 0; i < 12; i++) begin
                @(posedge mdc);
                hdr = {hdr[10:0], mdio_i};
            end
            if (hdr[11:10] == 2'b10) begin
                if (hdr[9:5] == PHY_ADDR) begin
                    @(negedge mdc);
                    @(negedge mdc);
                    phy_oe = 1'b1; phy_o = 1'b0;
                    for (int i = 0; i < 16; i++) begin
                        @(negedge mdc);
                        phy_o = phy_mem[hdr[4:0]][15-i];
                    end
                    @(negedge mdc);
                    phy_oe = 1'b0;
                end
            end else begin
                @(posedge mdc);
                @(posedge mdc);
                for (int i = 0; i < 16; i++) begin
                    @(posedge mdc);
                    d = {d[14:0], mdio_i};
                end
                if (hdr[9:5] == PHY_ADDR) phy_mem[hdr[4:0]] = d;
            end
        end
    end

    // ---------------- cycle reference model ----------------
    logic        m_cmd, m_active, m_launch, m_lrd, m_rd;
    logic [4:0]  m_dev, m_reg, m_fdev, m_freg;
    logic [15:0] m_wd, m_stat;
    logic        m_bits [FRAME];
    int          m_t;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmd = 0; m_active = 0; m_launch = 0; m_lrd = 0; m_rd = 0;
            m_dev = 0; m_reg = 0; m_wd = 0; m_stat = 0; m_t = 0;
            m_fdev = 0; m_freg = 0;
        end else begin
            logic lock;
            lock = m_active || m_launch;
            if (m_active) begin
                if (m_t == FRAME * DIV - 1) begin
                    m_active = 0;
                    if (m_rd) m_stat = (m_fdev == PHY_ADDR) ? exp_mem[m_freg] : 16'hFFFF;
                end else begin
                    m_t++;
                end
            end else if (m_launch) begin
                logic [31:0] tail;
                m_launch = 0; m_active = 1; m_t = 0; m_rd = m_lrd;
                m_fdev = m_dev; m_freg = m_reg;
                tail = {2'b01, m_rd ? 2'b10 : 2'b01, m_dev, m_reg,
                        m_rd ? 2'b00 : 2'b10, m_rd ? 16'h0 : m_wd};
                for (int i = 0; i < FRAME; i++)
                    m_bits[i] = (i < 32) ? 1'b1 : tail[63 - i];
                if (!m_rd && m_dev == PHY_ADDR) exp_mem[m_reg] = m_wd;
            end
            if (bus_we && !lock) begin
                case (bus_sel)
                    3'd0: begin
                        if (bus_wdata[0] && !m_cmd) begin m_launch = 1; m_lrd = 1; end
                        m_cmd = bus_wdata[0];
                    end
                    3'd1: begin m_dev = bus_wdata[12:8]; m_reg = bus_wdata[4:0]; end
                    3'd2: begin m_wd = bus_wdata; m_launch = 1; m_lrd = 0; end
                    default: ;
                endcase
            end
        end
    end

    // compare on every clock, away from the edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            logic e_mdc, e_oe, e_o;
            logic [31:0] e_rd;
            string rtag;
            int b;
            b = m_t / DIV;
            e_mdc = m_active && ((m_t % DIV) >= DIV / 2);
            e_oe  = m_active && ((b < 46) || !m_rd);
            e_o   = e_oe && m_bits[b];
            chk(m_active ? "R8 mdc" : "R10 mdc idle", {31'b0, mdc}, {31'b0, e_mdc});
            chk(m_active ? "R7 mdio_oe" : "R10 oe idle", {31'b0, mdio_oe}, {31'b0, e_oe});
            chk(m_active ? "R6 mdio_o" : "R10 o idle", {31'b0, mdio_o}, {31'b0, e_o});
            case (bus_sel)
                3'd0: begin e_rd = {31'b0, m_cmd};                    rtag = "R2 cmd readback"; end
                3'd1: begin e_rd = {19'b0, m_dev, 3'b0, m_reg};       rtag = "R1 addr readback"; end
                3'd2: begin e_rd = {16'b0, m_wd};                     rtag = "R3 wdata readback"; end
                3'd3: begin e_rd = {16'b0, m_stat};                   rtag = "R5 status"; end
                3'd4: begin e_rd = {31'b0, m_active};                 rtag = "R4 indicator"; end
                default: begin e_rd = 32'b0;                          rtag = "R1 unmapped"; end
            endcase
            chk(rtag, bus_rdata, e_rd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        bus_sel = sel; bus_wdata = data; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_sel = watch_sel;
    endtask

    task automatic wait_frame();
        repeat (FRAME * DIV + 8) @(negedge clk);
    endtask

    task automatic do_read(input logic [15:0] a);
        wr(3'd1, a); wr(3'd0, 16'h0); wr(3'd0, 16'h1);
        wait_frame();
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d);
        wr(3'd1, a); wr(3'd2, d);
        wait_frame();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state of every register (R1 R2 R3 R4 R5)
        for (int s = 0; s < 6; s++) begin
            bus_sel = 3'(s);
            #0.5;
            chk("R4 reset readback", bus_rdata, 32'h0);
            @(negedge clk);
        end
        bus_sel = watch_sel;

        // R2 read of device 2 register 1
        do_read(16'h0201);
        watch_sel = 3'd3; bus_sel = 3'd3; #0.5;
        chk("R5 read data dev2 reg1", bus_rdata, {16'b0, exp_mem[1]});

        // R2 set again without clearing: no new frame
        wr(3'd0, 16'h1);
        repeat (20) @(negedge clk);
        bus_sel = 3'd4; #0.5;
        chk("R2 no relaunch", bus_rdata, 32'h0);
        watch_sel = 3'd4;

        // R3 write, with R9 writes during the frame
        wr(3'd1, 16'h0205);
        wr(3'd2, 16'h1234);
        repeat (40) @(negedge clk);
        wr(3'd1, 16'h1F1F);
        wr(3'd2, 16'hDEAD);
        wr(3'd0, 16'h0);
        bus_sel = 3'd1; #0.5;
        chk("R9 addr locked", bus_rdata, 32'h0000_0205);
        bus_sel = 3'd2; #0.5;
        chk("R9 wdata locked", bus_rdata, 32'h0000_1234);
        watch_sel = 3'd1;
        wait_frame();
        watch_sel = 3'd3;
        do_read(16'h0205);
        bus_sel = 3'd3; #0.5;
        chk("R3 readback via frame", bus_rdata, 32'h0000_1234);

        // R5 absent device answers through pull-up
        do_read(16'h1106);
        bus_sel = 3'd3; #0.5;
        chk("R5 absent device", bus_rdata, 32'h0000_FFFF);

        // R6 boundary data and register numbers
        watch_sel = 3'd4;
        do_write(16'h021F, 16'hFFFF);
        do_write(16'h0200, 16'h8001);
        do_write(16'h0210, 16'h0000);
        watch_sel = 3'd3;
        do_read(16'h021F);
        bus_sel = 3'd3; #0.5;
        chk("R6 reg31 all ones", bus_rdata, 32'h0000_FFFF);
        do_read(16'h0200);
        bus_sel = 3'd3; #0.5;
        chk("R6 reg0 edge bits", bus_rdata, 32'h0000_8001);

        // R3 PHY contents after write frames
        chk("R3 phy reg5",  {16'b0, phy_mem[5]},  32'h0000_1234);
        chk("R3 phy reg31", {16'b0, phy_mem[31]}, 32'h0000_FFFF);
        chk("R3 phy reg0",  {16'b0, phy_mem[0]},  32'h0000_8001);
        chk("R3 phy reg16", {16'b0, phy_mem[16]}, 32'h0000_0000);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule